// File: doc/BRIEF.md
# Floating-Point Write-Port Reservation Register

This block sits in the decode stage of an in-order pipeline whose floating-point functional units have different latencies but share one register-file write port. Without it, a long-latency operation issued early and a short-latency one issued later could reach the write stage in the same cycle. At issue time the block reserves the single future cycle in which the decoded instruction will write. If that cycle is already taken, it holds fetch and decode instead.

Reservations are kept in a shift register that moves one position toward bit 0 every clock. Bit k stands for the write stage k+2 cycles in the future. The decoder gives a two-bit latency class. The block turns it into a slot position and tests that bit. A free slot is claimed and the instruction goes ahead in the same cycle. A taken slot raises the stall. The shift goes on during a stall, so on the next cycle the held instruction tests the slot that was one cycle further out, and it proceeds once that slot is clear.

Top module: `wb_slot_resv`

## Requirements
- R1: While `rstN` is low the reservation vector is all zeros and `stallFetch` is low. After reset is released the vector stays all zeros until the first claim.
- R2: On every clock the vector moves one bit toward bit 0 and a 0 enters the top bit. Bit k set means the write port is already claimed for the cycle k+2 cycles ahead, so the top bit is never 1 after a clock.
- R3: Latency code 0 is a load path of LOAD_STAGES (default 2) stages and tests bit 1. Code 1 is an add path of ADD_STAGES (default 4) stages and tests bit 3. Code 2 is a multiply path of MUL_STAGES (default 6) stages and tests bit 5. In general a path of S stages tests bit S-1. The vector is max(S) bits wide, 6 by default.
- R4: When a valid FP-writing instruction finds its tested bit clear, `stallFetch` is low in the same cycle. After the clock, bit S-2 of the vector is set, which is the claimed slot after one shift, on top of the shifted old contents.
- R5: When the tested bit is set, `stallFetch` is high in the same cycle. Nothing is claimed, and the vector only shifts.
- R6: An instruction held by a stall tests the shifted vector on the next cycle. It is granted in the first cycle its bit reads 0.
- R7: When `decValid` is low or `decWritesFp` is low, `stallFetch` is low, nothing is claimed, and the vector only shifts.
- R8: Latency code 3 is reserved. It behaves like an instruction that writes no FP register: no stall and no claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | An instruction is present in decode |
| decWritesFp | input | 1 | The decoded instruction writes an FP register |
| decLatCode | input | 2 | Latency class: 0 load, 1 add, 2 multiply, 3 reserved |
| stallFetch | output | 1 | Hold fetch and decode this cycle |
| resvVec | output | RESV_W (6) | Reservation vector; bit k is the write cycle k+2 ahead |

## Verification
A single multiply claim and a lone add or load claim show that each latency code tests and sets its own bit position. Back-to-back multiplies fill adjacent slots, which makes a following add collide twice before it is granted; this separates a correct retry against the shifted vector from one that retries against a stale bit. Load instructions trailing add and multiply claims hit the low slots, which checks that the bottom of the register drains. Invalid instructions, instructions that write no FP register, and the reserved code are mixed in against occupied vectors; they must neither stall nor leave a mark, which tells the qualifying logic apart from the shift path.

// File: rtl/wb_slot_resv_pkg.sv
package wb_slot_resv_pkg;

  // Widest slot index the strobe can carry (up to 16 slots).
  localparam int IDX_W = 4;

  typedef enum logic [1:0] {
    LAT_LOAD = 2'd0,
    LAT_ADD  = 2'd1,
    LAT_MUL  = 2'd2,
    LAT_NONE = 2'd3
  } latCode_e;

  // Strobes from control to the reservation datapath.
  typedef struct packed {
    logic             claim;
    logic [IDX_W-1:0] slot;   // bit index tested this cycle
  } resvCtrl_t;

  function automatic int maxOf3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wb_slot_resv_ctrl.sv
module wb_slot_resv_ctrl
  import wb_slot_resv_pkg::*;
#(
  parameter int LOAD_STAGES = 2,
  parameter int ADD_STAGES  = 4,
  parameter int MUL_STAGES  = 6,
  parameter int RESV_W      = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              decValid,
  input  logic              decWritesFp,
  input  logic [1:0]        decLatCode,
  input  logic [RESV_W-1:0] resvNow,
  output resvCtrl_t         ctrl,
  output logic              stall
);

  localparam logic [IDX_W-1:0] LoadIdx = IDX_W'(LOAD_STAGES - 1);
  localparam logic [IDX_W-1:0] AddIdx  = IDX_W'(ADD_STAGES - 1);
  localparam logic [IDX_W-1:0] MulIdx  = IDX_W'(MUL_STAGES - 1);

  logic             wantsSlot;
  logic [IDX_W-1:0] slotIdx;
  logic             slotBusy;

  always_comb begin
    wantsSlot = decValid && decWritesFp;
    slotIdx   = '0;
    unique case (latCode_e'(decLatCode))
      LAT_LOAD: slotIdx = LoadIdx;
      LAT_ADD:  slotIdx = AddIdx;
      LAT_MUL:  slotIdx = MulIdx;
      default:  wantsSlot = 1'b0;   // reserved code: no FP write
    endcase
  end

  // Read the tested bit without a variable part-select.
  always_comb begin
    slotBusy = 1'b0;
    for (int i = 0; i < RESV_W; i++) begin
      if (slotIdx == IDX_W'(i)) slotBusy = resvNow[i];
    end
  end

  always_comb begin
    stall      = wantsSlot && slotBusy;
    ctrl.claim = wantsSlot && !slotBusy;
    ctrl.slot  = slotIdx;
  end

  // R7: a stall needs a valid FP-writing instruction behind it.
  p_stall_needs_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (decValid && decWritesFp));

  // R4 / R5: claim and stall are never both asserted.
  p_claim_xor_stall_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.claim && stall));

endmodule

// File: rtl/wb_slot_resv_dp.sv
module wb_slot_resv_dp
  import wb_slot_resv_pkg::*;
#(
  parameter int RESV_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  resvCtrl_t         ctrl,
  output logic [RESV_W-1:0] resvQ
);

  logic [RESV_W-1:0] setMask;
  logic [RESV_W-1:0] resvD;

  // A claim on tested bit s lands at s-1, because the register shifts on the same edge.
  for (genvar g = 0; g < RESV_W; g++) begin : g_mask
    assign setMask[g] = ctrl.claim && (ctrl.slot == IDX_W'(g + 1));
  end

  assign resvD = {1'b0, resvQ[RESV_W-1:1]} | setMask;

  always_ff @(posedge clk) begin
    if (!rstN) resvQ <= '0;
    else       resvQ <= resvD;
  end

  // R2: nothing is ever parked in the top bit.
  p_top_bit_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    !resvQ[RESV_W-1]);

endmodule

// File: rtl/wb_slot_resv.sv
module wb_slot_resv
  import wb_slot_resv_pkg::*;
#(
  parameter int LOAD_STAGES = 2,
  parameter int ADD_STAGES  = 4,
  parameter int MUL_STAGES  = 6,
  localparam int RESV_W     = maxOf3(LOAD_STAGES, ADD_STAGES, MUL_STAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              decValid,
  input  logic              decWritesFp,
  input  logic [1:0]        decLatCode,
  output logic              stallFetch,
  output logic [RESV_W-1:0] resvVec
);

  resvCtrl_t ctrlStb;

  wb_slot_resv_ctrl #(
    .LOAD_STAGES(LOAD_STAGES),
    .ADD_STAGES (ADD_STAGES),
    .MUL_STAGES (MUL_STAGES),
    .RESV_W     (RESV_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .decValid   (decValid),
    .decWritesFp(decWritesFp),
    .decLatCode (decLatCode),
    .resvNow    (resvVec),
    .ctrl       (ctrlStb),
    .stall      (stallFetch)
  );

  wb_slot_resv_dp #(
    .RESV_W(RESV_W)
  ) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .ctrl (ctrlStb),
    .resvQ(resvVec)
  );

  logic reqFp;
  assign reqFp = decValid && decWritesFp && (decLatCode != 2'd3);

  // R4: a granted request adds exactly one reservation beyond the shifted contents.
  p_grant_adds_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqFp && !stallFetch) |=>
      ($countones(resvVec) == $countones($past(resvVec) >> 1) + 1));

  // R5: a stalled cycle only shifts.
  p_stall_only_shifts_r5: assert property (@(posedge clk) disable iff (!rstN)
    stallFetch |=> (resvVec == ($past(resvVec) >> 1)));

  // R7 / R8: a cycle with no qualifying request only shifts.
  p_idle_only_shifts_r7: assert property (@(posedge clk) disable iff (!rstN)
    !reqFp |=> (resvVec == ($past(resvVec) >> 1)));

  // R8: the reserved code never stalls.
  p_reserved_no_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    (decLatCode == 2'd3) |-> !stallFetch);

endmodule

// File: tb/wb_slot_resv_test.sv
module wb_slot_resv_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       decValid;
  logic       decWritesFp;
  logic [1:0] decLatCode;
  logic       stallFetch;
  logic [5:0] resvVec;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;   // 50 MHz

  wb_slot_resv uut (
    .clk        (clk),
    .rstN       (rstN),
    .decValid   (decValid),
    .decWritesFp(decWritesFp),
    .decLatCode (decLatCode),
    .stallFetch (stallFetch),
    .resvVec    (resvVec)
  );

  // {valid, writesFp, code, expected stall, expected vector after the edge}
  localparam int NVEC = 23;
  localparam logic [10:0] VECS [NVEC] = '{
    {1'b1, 1'b1, 2'd2, 1'b0, 6'h10},  // mul claims bit 5
    {1'b1, 1'b1, 2'd1, 1'b0, 6'h0C},  // add claims bit 3
    {1'b1, 1'b1, 2'd1, 1'b1, 6'h06},  // add collides with mul
    {1'b1, 1'b1, 2'd1, 1'b0, 6'h07},  // retry granted
    {1'b1, 1'b0, 2'd1, 1'b0, 6'h03},  // no FP write
    {1'b1, 1'b1, 2'd0, 1'b1, 6'h01},  // load collides
    {1'b1, 1'b1, 2'd0, 1'b0, 6'h01},  // load retry granted
    {1'b0, 1'b1, 2'd2, 1'b0, 6'h00},  // invalid
    {1'b1, 1'b1, 2'd3, 1'b0, 6'h00},  // reserved code
    {1'b1, 1'b1, 2'd2, 1'b0, 6'h10},
    {1'b1, 1'b1, 2'd2, 1'b0, 6'h18},
    {1'b1, 1'b1, 2'd2, 1'b0, 6'h1C},
    {1'b1, 1'b1, 2'd1, 1'b1, 6'h0E},  // add blocked twice
    {1'b1, 1'b1, 2'd1, 1'b1, 6'h07},
    {1'b1, 1'b1, 2'd1, 1'b0, 6'h07},
    {1'b1, 1'b1, 2'd0, 1'b1, 6'h03},
    {1'b1, 1'b1, 2'd0, 1'b1, 6'h01},
    {1'b1, 1'b1, 2'd0, 1'b0, 6'h01},
    {1'b1, 1'b0, 2'd2, 1'b0, 6'h00},
    {1'b1, 1'b1, 2'd2, 1'b0, 6'h10},
    {1'b1, 1'b1, 2'd0, 1'b0, 6'h09},
    {1'b1, 1'b1, 2'd1, 1'b1, 6'h04},
    {1'b0, 1'b0, 2'd0, 1'b0, 6'h02}
  };

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic f, input logic [1:0] c);
    decValid = v; decWritesFp = f; decLatCode = c;
  endtask

  // Present one instruction; check stall before the edge, then the vector after it.
  task automatic step(input logic v, input logic f, input logic [1:0] c,
                      input logic expStall, input logic [5:0] expVec,
                      input string stallTag, input string vecTag);
    @(negedge clk);
    drive(v, f, c);
    #1;
    check(stallTag, {5'd0, stallFetch}, {5'd0, expStall});
    @(posedge clk);
    #1;
    check(vecTag, resvVec, expVec);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic prevStall;
    string tag;
    rstN = 1'b0;
    drive(1'b1, 1'b1, 2'd2);
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset vector", resvVec, 6'h00);
    check("R1 reset stall", {5'd0, stallFetch}, 6'h00);
    @(negedge clk);
    drive(1'b0, 1'b0, 2'd0);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R1 idle after reset", resvVec, 6'h00);

    prevStall = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      logic [10:0] e;
      e = VECS[i];
      if (!e[10] || !e[9])      tag = "R7";
      else if (e[8:7] == 2'd3)  tag = "R8";
      else if (e[6])            tag = "R5";
      else if (prevStall)       tag = "R6";
      else                      tag = "R4";
      step(e[10], e[9], e[8:7], e[6], e[5:0],
           $sformatf("%s stall vec%0d", tag, i),
           $sformatf("R2 %s vector vec%0d", tag, i));
      prevStall = e[6];
    end

    // R3: each code marks its own slot, viewed one edge after the claim.
    step(1'b0, 1'b0, 2'd0, 1'b0, 6'h01, "R7 drain", "R2 drain");
    step(1'b0, 1'b0, 2'd0, 1'b0, 6'h00, "R7 drain", "R2 drain");
    step(1'b1, 1'b1, 2'd0, 1'b0, 6'h01, "R3 load stall", "R3 load bit");
    step(1'b1, 1'b1, 2'd1, 1'b0, 6'h04, "R3 add stall", "R3 add bit");
    step(1'b1, 1'b1, 2'd2, 1'b0, 6'h12, "R3 mul stall", "R3 mul bit");

    // R6: a mul held behind nothing; an add held until the mul slot passes.
    step(1'b1, 1'b1, 2'd2, 1'b0, 6'h19, "R4 mul stall", "R4 mul vector");
    step(1'b1, 1'b1, 2'd1, 1'b1, 6'h0C, "R6 first try", "R6 shifted");
    step(1'b1, 1'b1, 2'd1, 1'b1, 6'h06, "R6 second try", "R6 shifted");
    step(1'b1, 1'b1, 2'd1, 1'b0, 6'h07, "R6 granted", "R6 claim");

    // R1: reset mid-run clears a populated vector.
    @(negedge clk);
    rstN = 1'b0;
    drive(1'b1, 1'b1, 2'd1);
    @(posedge clk);
    #1;
    check("R1 mid-run reset vector", resvVec, 6'h00);
    check("R1 mid-run reset stall", {5'd0, stallFetch}, 6'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule